// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Pin Interrupt Detection

This block is a general-purpose I/O controller for sixteen pins behind a small single-cycle register bus. Software picks each pin's direction, sets the level driven on output pins, and reads the level seen on every pin. In the direction register a set bit makes the pin an input. Each pin's input passes through a two-flop synchroniser. The synchronised value feeds the input register and a trigger detector for that pin.

Each pin has its own 3-bit trigger style. The styles cover both levels, either edge, or any change. A detected event sets the pin's bit in a status register. Software clears a status bit by writing 1 to it. Each status bit drives its own interrupt line toward the system interrupt controller. A level-style pin keeps its status bit set for as long as its level holds, even if software tries to clear it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input: the direction register reads 0xFFFF and `pin_oe` is 0. The output register reads 0 and the status register reads 0. Both style registers read 0xFFFFFF, so every field holds code 7 and detection is off.
- R2: The direction register is at offset 0. A 1 in bit n makes pin n an input (`pin_oe[n]`=0). A 0 makes it an output (`pin_oe[n]`=1). A write takes effect on the clock edge that samples it.
- R3: The output register is at offset 1. Its value drives `pin_out` directly and reads back unchanged.
- R4: The input register is at offset 2. It reads the pin level through the two-flop synchroniser, so a change on `pin_in` shows up after the second rising edge. Writes to offset 2 have no effect.
- R5: Style register A is at offset 3 and holds pins 0-7. Style register B is at offset 4 and holds pins 8-15. Pin n's 3-bit field starts at bit 3*(n mod 8).
- R6: Style code 0 sets the status bit while the synchronised pin is high. Style code 1 sets it while the pin is low.
- R7: Style code 2 sets the status bit on a rising edge. Code 3 sets it on a falling edge. Code 4 sets it on either edge. An edge means the synchronised value differs from its value one cycle earlier.
- R8: Style codes 5, 6 and 7 never set the status bit.
- R9: The status register is at offset 5. Writing 1 to a bit clears it and writing 0 leaves it alone. A status bit never falls except on a clearing write.
- R10: If a clearing write lands while a level-style condition still holds, the status bit stays set.
- R11: When a new event and a clearing write for the same pin land on the same edge, the event wins and the bit stays set.
- R12: `irq_out[n]` shows status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Levels to drive |
| pin_oe | output | 16 | Output enable per pin, 1 = drive |
| irq_out | output | 16 | Interrupt request per pin |

## Verification
The most delicate overlap is a trigger event and a write-1-to-clear for the same pin landing on the same clock edge. The bench sets a rising-edge style and raises the pin. It then times a clearing write so that the write is sampled on exactly the edge where the synchronised edge reaches the status register. It expects the bit to survive that write. A later clearing write with no event is expected to clear the bit. The level-style case overlaps in the same way: a clear written while the level still holds is judged by the status bit reading 1 afterwards.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int STYLE_W = 3;

  typedef enum logic [STYLE_W-1:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_ANY  = 3'd4
  } trig_e;

  // fixed register offsets; style registers follow OFS_STYLE0 contiguously
  localparam int OFS_DIR    = 0;
  localparam int OFS_OUT    = 1;
  localparam int OFS_IN     = 2;
  localparam int OFS_STYLE0 = 3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // trigger decision for one pin from its style code and two samples
  function automatic logic trig_hit(input logic [STYLE_W-1:0] code,
                                    input logic cur, input logic prev);
    logic r;
    case (code)
      TRIG_HIGH: r = cur;
      TRIG_LOW:  r = ~cur;
      TRIG_RISE: r = cur & ~prev;
      TRIG_FALL: r = ~cur & prev;
      TRIG_ANY:  r = cur ^ prev;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // lowest bit of a pin's style field inside its style register
  function automatic int field_lsb(input int pin, input int per_reg);
    return (pin % per_reg) * STYLE_W;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic [NPINS-1:0]         cur_i,
  input  logic [NPINS-1:0]         prev_i,
  input  logic [NPINS*STYLE_W-1:0] style_i,
  output logic [NPINS-1:0]         hit_o
);

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      assign hit_o[p] = trig_hit(style_i[p*STYLE_W +: STYLE_W], cur_i[p], prev_i[p]);
    end
  endgenerate

endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] status_o
);

  logic [NPINS-1:0] status_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else status_q <= (status_q & ~clr_i) | hit_i;
  end

  assign status_o = status_q;

  // R11 / R10: an event always leaves its bit set on the next cycle
  p_hit_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((status_q & $past(hit_i)) == $past(hit_i)));

  // R9: a clear with no competing event drops the bit
  p_w1c_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~hit_i) != '0) |=> ((status_q & $past(clr_i & ~hit_i)) == '0));

  // R9: no bit falls without a clearing write
  p_no_spurious_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~status_q & ~$past(clr_i)) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter  int NPINS        = 16,
  parameter  int PINS_PER_REG = 8,
  localparam int NUM_STYLE    = (NPINS + PINS_PER_REG - 1) / PINS_PER_REG,
  localparam int OFS_STAT     = OFS_STYLE0 + NUM_STYLE,
  localparam int ADDR_W       = $clog2(OFS_STAT + 1),
  localparam int FIELD_W      = PINS_PER_REG * STYLE_W,
  localparam int DATA_W       = imax(NPINS, FIELD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  irq_out
);

  logic                     wr_en;
  logic [NPINS-1:0]         dir_q;
  logic [NPINS-1:0]         out_q;
  logic [FIELD_W-1:0]       style_q [NUM_STYLE];
  logic [NPINS-1:0]         sync_lvl;
  logic [NPINS-1:0]         prev_lvl_q;
  logic [NPINS*STYLE_W-1:0] style_flat;
  logic [NPINS-1:0]         trig_hit_w;
  logic [NPINS-1:0]         clear_req_w;
  logic [NPINS-1:0]         status_w;

  assign wr_en = bus_sel & bus_wr;

  // direction and output registers; offset 2 (input) has no write path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == ADDR_W'(OFS_DIR)) dir_q <= bus_wdata[NPINS-1:0];
      if (bus_addr == ADDR_W'(OFS_OUT)) out_q <= bus_wdata[NPINS-1:0];
    end
  end

  genvar k, p;
  generate
    for (k = 0; k < NUM_STYLE; k++) begin : g_style_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) style_q[k] <= '1;
        else if (wr_en && bus_addr == ADDR_W'(OFS_STYLE0 + k))
          style_q[k] <= bus_wdata[FIELD_W-1:0];
      end
    end
    for (p = 0; p < NPINS; p++) begin : g_style_map
      assign style_flat[p*STYLE_W +: STYLE_W] =
        style_q[p / PINS_PER_REG][field_lsb(p, PINS_PER_REG) +: STYLE_W];
    end
  endgenerate

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in),
    .q_o   (sync_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl_q <= '0;
    else prev_lvl_q <= sync_lvl;
  end

  gpio_trig_detect #(.NPINS(NPINS)) u_detect (
    .cur_i   (sync_lvl),
    .prev_i  (prev_lvl_q),
    .style_i (style_flat),
    .hit_o   (trig_hit_w)
  );

  assign clear_req_w = (wr_en && bus_addr == ADDR_W'(OFS_STAT)) ?
                       bus_wdata[NPINS-1:0] : '0;

  gpio_status #(.NPINS(NPINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (trig_hit_w),
    .clr_i    (clear_req_w),
    .status_o (status_w)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq_out = status_w;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_DIR):  bus_rdata[NPINS-1:0] = dir_q;
      ADDR_W'(OFS_OUT):  bus_rdata[NPINS-1:0] = out_q;
      ADDR_W'(OFS_IN):   bus_rdata[NPINS-1:0] = sync_lvl;
      ADDR_W'(OFS_STAT): bus_rdata[NPINS-1:0] = status_w;
      default: begin
        for (int i = 0; i < NUM_STYLE; i++)
          if (bus_addr == ADDR_W'(OFS_STYLE0 + i))
            bus_rdata[FIELD_W-1:0] = style_q[i];
      end
    endcase
  end

  // R2: a direction write shows up inverted on the enables one edge later
  p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == ~$past(bus_wdata[NPINS-1:0])));

  // R3: an output write shows up on the pins one edge later
  p_out_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == ADDR_W'(OFS_OUT)) |=> (pin_out == $past(bus_wdata[NPINS-1:0])));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [23:0] bus_wdata = 0;
  logic [23:0] bus_rdata;
  logic [15:0] pin_in = 0;
  logic [15:0] pin_out, pin_oe, irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    bus_addr = a; bus_sel = 1; bus_wr = 0;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // style register value giving one pin a code and all others code 7
  function automatic logic [23:0] style_word(input int reg_idx, input int pin, input int code);
    logic [23:0] v = 24'hFFFFFF;
    if (pin / 8 == reg_idx) begin
      v[(pin % 8) * 3 +: 3] = code[2:0];
    end
    return v;
  endfunction

  // expected status for the sweep steps:
  // 0 low+clear, 1 raised, 2 high+clear, 3 lowered, 4 low+clear
  function automatic bit sweep_exp(input int code, input int step);
    case (step)
      0: return code == 1;
      1: return code == 0 || code == 1 || code == 2 || code == 4;
      2: return code == 0;
      3: return code == 0 || code == 1 || code == 3 || code == 4;
      default: return code == 1;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] r;
    string tag;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset values
    rd(3'd0, r); check("R1 dir", r, 24'h00FFFF);
    check("R1 oe", {8'h0, pin_oe}, 24'h0);
    rd(3'd1, r); check("R1 out", r, 24'h0);
    rd(3'd5, r); check("R1 status", r, 24'h0);
    rd(3'd3, r); check("R1 styleA", r, 24'hFFFFFF);
    rd(3'd4, r); check("R1 styleB", r, 24'hFFFFFF);

    // R2 inverted direction
    wr(3'd0, 24'h0000F0);
    check("R2 oe", {8'h0, pin_oe}, 24'h00FF0F);
    rd(3'd0, r); check("R2 dir readback", r, 24'h0000F0);
    wr(3'd0, 24'h00FFFF);
    check("R2 oe all inputs", {8'h0, pin_oe}, 24'h0);

    // R3 output register
    wr(3'd1, 24'h00A5C3);
    check("R3 pin_out", {8'h0, pin_out}, 24'h00A5C3);
    rd(3'd1, r); check("R3 readback", r, 24'h00A5C3);

    // R4 two-stage latency and ignored writes
    @(negedge clk); pin_in = 16'h1234;
    rd(3'd2, r); check("R4 before edges", r, 24'h0);
    @(negedge clk); rd(3'd2, r); check("R4 after one edge", r, 24'h0);
    @(negedge clk); rd(3'd2, r); check("R4 after two edges", r, 24'h001234);
    wr(3'd2, 24'h00FFFF);
    rd(3'd2, r); check("R4 write ignored", r, 24'h001234);
    pin_in = 16'h0;
    idle(4);

    // R5 field placement readback
    wr(3'd4, style_word(1, 13, 2));
    rd(3'd4, r); check("R5 pin13 field", r, 24'hFFFFFF & ~(24'h5 << 15));
    wr(3'd4, 24'hFFFFFF);

    // R11 event and clear on the same edge
    wr(3'd3, style_word(0, 3, 2));
    idle(4);
    wr(3'd5, 24'h00FFFF);
    @(negedge clk); pin_in[3] = 1'b1;
    @(negedge clk);
    wr(3'd5, 24'h000008);
    rd(3'd5, r); check("R11 set beats clear", r, 24'h000008);
    check("R12 irq during collision", {8'h0, irq_out}, 24'h000008);
    wr(3'd5, 24'h000008);
    rd(3'd5, r); check("R9 later clear", r, 24'h0);
    wr(3'd5, 24'h000000);
    pin_in[3] = 1'b0;
    idle(4);
    wr(3'd3, 24'hFFFFFF);
    wr(3'd5, 24'h00FFFF);

    // R6 R7 R8 R9 R10 R12 sweep over every pin and every style code
    for (int pin = 0; pin < 16; pin++) begin
      for (int code = 0; code < 8; code++) begin
        tag = (code < 2) ? "R6/R10" : (code < 5) ? "R7" : "R8";
        wr(3'd3, style_word(0, pin, code));
        wr(3'd4, style_word(1, pin, code));
        pin_in = 16'h0;
        idle(4);
        wr(3'd5, 24'h00FFFF); idle(4);
        rd(3'd5, r); check($sformatf("%s pin%0d code%0d step0", tag, pin, code), r, 24'(sweep_exp(code, 0)) << pin);
        pin_in[pin] = 1'b1; idle(4);
        rd(3'd5, r); check($sformatf("%s pin%0d code%0d step1", tag, pin, code), r, 24'(sweep_exp(code, 1)) << pin);
        check($sformatf("R12 irq pin%0d code%0d", pin, code), {8'h0, irq_out}, 24'(sweep_exp(code, 1)) << pin);
        wr(3'd5, 24'h000000); idle(1);
        rd(3'd5, r); check($sformatf("R9 zero write pin%0d code%0d", pin, code), r, 24'(sweep_exp(code, 1)) << pin);
        wr(3'd5, 24'h00FFFF); idle(4);
        rd(3'd5, r); check($sformatf("R10 pin%0d code%0d step2", pin, code), r, 24'(sweep_exp(code, 2)) << pin);
        pin_in[pin] = 1'b0; idle(4);
        rd(3'd5, r); check($sformatf("%s pin%0d code%0d step3", tag, pin, code), r, 24'(sweep_exp(code, 3)) << pin);
        wr(3'd5, 24'h00FFFF); idle(4);
        rd(3'd5, r); check($sformatf("R10 pin%0d code%0d step4", pin, code), r, 24'(sweep_exp(code, 4)) << pin);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule